// File: doc/BRIEF.md
# Capability Dword Select Window

This block gives configuration software indirect access to a controller's register file through an 8-byte capability. The capability has two dwords. The first dword holds a select byte and a status byte. The second dword is a 32-bit data register. The select byte names one register-file dword, whose byte address is the select value times four. A configuration write that touches the data register passes the whole 32-bit data value on to the selected dword. After any configuration write to the capability, the data register is filled again from the selected dword. The data register therefore always mirrors the dword chosen by the select byte.

A three-state machine sequences the work.
- `ST_IDLE`: the block accepts configuration writes.
- `ST_FWD`: the block issues a one-cycle register-file write.
- `ST_LOAD`: the block captures the selected dword into the data register.

The transitions are:
- `ST_IDLE` to `ST_FWD` on a write that touches the data register.
- `ST_IDLE` to `ST_LOAD` on a write that touches only the first dword.
- `ST_FWD` to `ST_LOAD` always.
- `ST_LOAD` to `ST_IDLE` always.

Reset enters `ST_LOAD`, so the data register starts as a copy of dword 0. The forward always happens before the reload. A readback therefore shows the register file's response to the write, for example bits cleared by write-one-to-clear fields. Select values at or beyond the implemented size read as zero, and the block suppresses writes to them.

Top module: `cfg_dword_window`

## Requirements
- R1: After reset the select byte is 0 and `cfg_ready` is high from the second clock edge onward. The data register then holds the register-file dword at index 0.
- R2: A configuration read with `cfg_dw_sel`=0 returns {8'h00 status, select byte, 16'h0000}, with the select byte in bits 23:16. A read with `cfg_dw_sel`=1 returns the data register.
- R3: A write with `cfg_dw_sel`=0 and `cfg_be[2]`=1 loads `cfg_wdata[23:16]` into the select byte. Bytes 0, 1 and 3 of the first dword ignore writes and keep reading as zero.
- R4: A write with `cfg_dw_sel`=1 merges each data byte whose `cfg_be` bit is set. In the next cycle, `rf_we` pulses for exactly one cycle with the full merged 32-bit value on `rf_wdata` and the select value on `rf_addr`.
- R5: Every accepted write reloads the data register from the selected dword. `cfg_ready` is low for one cycle after a write to the first dword, and for two cycles after a write to the data register.
- R6: The register-file write happens before the reload. Reading the data register back therefore returns the dword as the register file holds it after the write.
- R7: When the select value is RF_DWORDS or greater, `rf_we` never pulses and the data register reloads as zero.
- R8: A configuration write presented while `cfg_ready` is low is ignored. It changes neither the select byte nor the data register.
- R9: A write with `cfg_be`=0 is ignored entirely. It causes no register-file write, no reload and no drop of `cfg_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_sel | input | 1 | Capability dword: 0 = select/status dword, 1 = data dword |
| cfg_be | input | 4 | Byte enables for the addressed dword |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the addressed dword |
| cfg_ready | output | 1 | High when a configuration write can be accepted |
| rf_addr | output | SEL_W | Register-file dword index (byte address / 4) |
| rf_we | output | 1 | Register-file write pulse |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data for `rf_addr`, combinational |

## Verification
The bench applies a write at one clock edge and then counts the falling edges until `cfg_ready` returns. It expects one busy sample for a write to the first dword and two for a write to the data register. The register-file write pulse is due one cycle after the data write. The bench's register-file model records that pulse and its address as it happens. The data register and the select byte are read only once `cfg_ready` is high again. At that point both the forward and the reload have finished, so the expected value comes straight from the bench's own register-file model.

// File: rtl/capwin_pkg.sv
package capwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_LOAD = 2'd2
    } win_state_t;

    localparam int SEL_BYTE_LANE = 2;
    localparam int DATA_W        = 32;
    localparam int LANES         = DATA_W / 8;
endpackage

// File: rtl/capwin_fsm.sv
module capwin_fsm
    import capwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic data_hit,
    output logic ready,
    output logic fwd_now,
    output logic load_now
);
    win_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_hit) state_d = data_hit ? ST_FWD : ST_LOAD;
            ST_FWD:  state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        fwd_now  = 1'b0;
        load_now = 1'b0;
        unique case (state_q)
            ST_IDLE: ready    = 1'b1;
            ST_FWD:  fwd_now  = 1'b1;
            ST_LOAD: load_now = 1'b1;
            default: ready    = 1'b0;
        endcase
    end

    AST_FWD_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_now |=> (load_now && !fwd_now)); // R6
    AST_LOAD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> ready); // R5
endmodule

// File: rtl/capwin_range.sv
module capwin_range #(
    parameter int SEL_W     = 8,
    parameter int RF_DWORDS = 8
) (
    input  logic [SEL_W-1:0] sel,
    output logic             in_range
);
    localparam int SPAN = 1 << SEL_W;
    generate
        if (RF_DWORDS >= SPAN) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (int'(sel) < RF_DWORDS);
        end
    endgenerate
endmodule

// File: rtl/capwin_regs.sv
module capwin_regs
    import capwin_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic              dw_sel,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_now,
    input  logic              in_range,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] data_q
);
    logic [DATA_W-1:0] data_merged;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign data_merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : data_q[g*8 +: 8];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_acc && !dw_sel && be[SEL_BYTE_LANE]) begin
            sel_q <= wdata[SEL_BYTE_LANE*8 +: SEL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_now) begin
            data_q <= in_range ? rf_rdata : '0;
        end else if (wr_acc && dw_sel) begin
            data_q <= data_merged;
        end
    end
endmodule

// File: rtl/cfg_dword_window.sv
module cfg_dword_window
    import capwin_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int RF_DWORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_dw_sel,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             cfg_ready,
    output logic [SEL_W-1:0] rf_addr,
    output logic             rf_we,
    output logic [31:0]      rf_wdata,
    input  logic [31:0]      rf_rdata
);
    logic             wr_acc, fwd_now, load_now, in_range;
    logic [SEL_W-1:0] sel_q;
    logic [31:0]      data_q;
    logic [31:0]      sel_word;

    assign wr_acc = cfg_ready && cfg_we && (|cfg_be);

    capwin_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_acc),
        .data_hit (cfg_dw_sel),
        .ready    (cfg_ready),
        .fwd_now  (fwd_now),
        .load_now (load_now)
    );

    capwin_range #(.SEL_W(SEL_W), .RF_DWORDS(RF_DWORDS)) u_range (
        .sel      (sel_q),
        .in_range (in_range)
    );

    capwin_regs #(.SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .dw_sel   (cfg_dw_sel),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .load_now (load_now),
        .in_range (in_range),
        .rf_rdata (rf_rdata),
        .sel_q    (sel_q),
        .data_q   (data_q)
    );

    always_comb begin
        sel_word = '0;
        sel_word[SEL_BYTE_LANE*8 +: SEL_W] = sel_q;
    end

    assign cfg_rdata = cfg_dw_sel ? data_q : sel_word;
    assign rf_addr   = sel_q;
    assign rf_we     = fwd_now && in_range;
    assign rf_wdata  = data_q;

    AST_RF_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (int'(rf_addr) < RF_DWORDS)); // R7
    AST_RF_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we); // R4
    AST_SEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |=> $stable(rf_addr)); // R8
    AST_DATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && !(cfg_we && (|cfg_be))) |=> $stable(data_q)); // R9
endmodule

// File: tb/cfg_dword_window_test.sv
module cfg_dword_window_test;
    localparam int SEL_W = 8;
    localparam int NDW   = 8;
    localparam int W1C_IDX = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_dw_sel = 1'b0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata, rf_wdata, rf_rdata;
    logic cfg_ready, rf_we;
    logic [SEL_W-1:0] rf_addr;

    logic [31:0] mem [NDW];
    int errors = 0, checks = 0, we_pulses = 0, bad_we = 0;
    logic [31:0] cur_data;
    logic [7:0]  cur_sel;

    always #4 clk = ~clk;

    cfg_dword_window #(.SEL_W(SEL_W), .RF_DWORDS(NDW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw_sel(cfg_dw_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_ready(cfg_ready), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = (int'(rf_addr) < NDW) ? mem[rf_addr] : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (rf_we) begin
            we_pulses++;
            if (int'(rf_addr) >= NDW) bad_we++;
            else if (int'(rf_addr) == W1C_IDX) mem[rf_addr] <= mem[rf_addr] & ~rf_wdata;
            else mem[rf_addr] <= rf_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic dw, output logic [31:0] v);
        cfg_dw_sel = dw;
        #1 v = cfg_rdata;
    endtask

    // Drives a write at a negedge, returns number of negedge samples with ready low.
    task automatic wr(input logic dw, input logic [3:0] be, input logic [31:0] d, output int busy);
        while (!cfg_ready) @(negedge clk);
        cfg_we = 1'b1; cfg_dw_sel = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
        busy = 0;
        while (!cfg_ready && busy < 10) begin busy++; @(negedge clk); end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, exp, wv;
        int busy, p0;
        for (int i = 0; i < NDW; i++) mem[i] = 32'h1000_0001 * (i + 3);
        mem[W1C_IDX] = 32'hFFFF_00FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 ready", {31'd0, cfg_ready}, 32'd1);
        rd(1'b0, v); check("R1 R2 select/status after reset", v, 32'h0);
        rd(1'b1, v); check("R1 data mirrors dword0", v, mem[0]);

        // R3: select sweep including out-of-range values; other lanes ignored
        for (int s = 0; s < 10; s++) begin
            wr(1'b0, 4'hF, {8'hA5, 8'(s), 16'hC3C3}, busy);
            check("R5 busy after select write", busy, 1);
            rd(1'b0, v); check("R3 select readback, other bytes zero", v, {8'h00, 8'(s), 16'h0});
            rd(1'b1, v);
            exp = (s < NDW) ? mem[s] : 32'h0;
            check("R5 R7 reload after select", v, exp);
        end

        // R4 R6: data writes with varying byte enables on every dword
        for (int s = 0; s < NDW; s++) begin
            wr(1'b0, 4'b0100, {8'h0, 8'(s), 16'h0}, busy);
            for (int be = 1; be < 16; be += 5) begin
                rd(1'b1, cur_data);
                wv = 32'h5A00_00A5 ^ (s * 32'h0101_0101) ^ (be << 8);
                exp = merge(cur_data, wv, 4'(be));
                if (s == W1C_IDX) exp = mem[s] & ~exp;
                p0 = we_pulses;
                wr(1'b1, 4'(be), wv, busy);
                check("R5 busy after data write", busy, 2);
                check("R4 one forward pulse", we_pulses - p0, 1);
                rd(1'b1, v); check("R4 R6 data readback", v, exp);
                check("R4 register file updated", mem[s], exp);
            end
        end

        // R7: out of range data write suppressed
        wr(1'b0, 4'b0100, {8'h0, 8'd200, 16'h0}, busy);
        p0 = we_pulses;
        wr(1'b1, 4'hF, 32'h1234_5678, busy);
        check("R7 no rf write", we_pulses - p0, 0);
        check("R7 no bad write", bad_we, 0);
        rd(1'b1, v); check("R7 reload zero", v, 32'h0);

        // R8: write during busy ignored
        wr(1'b0, 4'b0100, {8'h0, 8'd2, 16'h0}, busy);
        while (!cfg_ready) @(negedge clk);
        cfg_we = 1'b1; cfg_dw_sel = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'hCAFE_0000;
        @(negedge clk);
        cfg_dw_sel = 1'b0; cfg_be = 4'hF; cfg_wdata = 32'h0005_0000;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 4'h0;
        while (!cfg_ready) @(negedge clk);
        rd(1'b0, v); check("R8 select unchanged by busy write", v, 32'h0002_0000);
        rd(1'b1, v); check("R8 data from accepted write only", v, 32'hCAFE_0000);

        // R9: zero byte enables
        p0 = we_pulses;
        wr(1'b1, 4'h0, 32'hFFFF_FFFF, busy);
        check("R9 no busy", busy, 0);
        check("R9 no rf write", we_pulses - p0, 0);
        rd(1'b1, v); check("R9 data unchanged", v, 32'hCAFE_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule